// File: doc/BRIEF.md
# Multi-Mode Universal Shift Register

A clocked register, eight bits wide by default, that accepts data either bit by bit through a serial input or all at once through a parallel bus. It presents its contents either as a parallel word or as a single serial bit. A two-bit style field chooses how data enters and leaves. A three-bit operation field chooses what happens at each rising clock edge: hold, load, load combined with a one-place shift, rotation, or an arithmetic shift.

The style field codes are 00 serial-in/parallel-out, 01 serial-in/serial-out, 10 parallel-in/serial-out and 11 parallel-in/parallel-out. The high style bit means the data enters in parallel. Style codes 00 and 11 have a parallel output. The serial output follows the direction of the most recent directional operation, so a chain of shifts in one direction streams bits out of the leading end. Reset is synchronous and active high. Every change happens on the rising edge of the clock.

Top module: `shreg_univ`

## Requirements
- R1: While `rst` is high at a rising edge, the register clears and the serial direction returns to right, so `par_out` and `ser_out` are 0 afterwards.
- R2: Operation 000 leaves the register and the serial direction unchanged.
- R3: Operation 001 in styles 10/11 stores `par_in` and keeps the direction. In styles 00/01 it stores `{ser_in, q[W-1:1]}` and sets the direction to right.
- R4: Operation 010 stores the loaded value shifted right by one, with `ser_in` entering the MSB. The loaded value is `par_in` in styles 10/11 and the register itself in styles 00/01. It sets the direction to right.
- R5: Operation 011 stores the loaded value shifted left by one, with `ser_in` entering bit 0. The loaded value follows the same source rule as R4. It sets the direction to left.
- R6: Operation 100 rotates the register right by one, and operation 101 rotates it left by one. They set the direction to right and to left respectively.
- R7: Operation 110 shifts right by one and copies the old bit W-1 into bit W-1. It sets the direction to right.
- R8: Operation 111 keeps bit W-1, moves bits W-3..0 up one place and clears bit 0. It sets the direction to left.
- R9: `ser_out` is bit 0 of the register when the direction is right and bit W-1 when it is left.
- R10: `par_out` equals the register in styles 00 and 11 and is all zeros in styles 01 and 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| io_mode | input | 2 | I/O style: 00 SIPO, 01 SISO, 10 PISO, 11 PIPO |
| op | input | 3 | Per-clock operation code 000..111 |
| par_in | input | W | Parallel data input |
| ser_in | input | 1 | Serial data input |
| par_out | output | W | Parallel output, zero in serial-out styles |
| ser_out | output | 1 | Serial output bit |

## Verification
The bench goes after three things.

The first is the source of loaded data in each style. A design that took `par_in` in a serial-in style would show a whole foreign word on the following parallel readback.

The second is the sign handling of both arithmetic shifts. A wrong fill shows up as a flipped top or bottom bit after a run of 110 or 111 operations on a negative value.

The third is the serial direction memory across hold and parallel load. A design that reset or recomputed the direction there would present the wrong end bit on `ser_out`. The style gating of `par_out` is checked under every style change, so a leak of the register in a serial-out style appears at once.

// File: rtl/shreg_univ_pkg.sv
package shreg_univ_pkg;

    typedef enum logic [1:0] {
        IO_SIPO = 2'b00,
        IO_SISO = 2'b01,
        IO_PISO = 2'b10,
        IO_PIPO = 2'b11
    } io_style_e;

    typedef enum logic [2:0] {
        OP_HOLD = 3'b000,
        OP_LOAD = 3'b001,
        OP_LDSR = 3'b010,
        OP_LDSL = 3'b011,
        OP_ROTR = 3'b100,
        OP_ROTL = 3'b101,
        OP_ASR  = 3'b110,
        OP_ASL  = 3'b111
    } op_e;

    typedef enum logic {
        DIR_RIGHT = 1'b0,
        DIR_LEFT  = 1'b1
    } dir_e;

    typedef enum logic [2:0] {
        SH_KEEP,
        SH_PASS,
        SH_RIGHT,
        SH_LEFT,
        SH_ROTR,
        SH_ROTL,
        SH_ASR,
        SH_ASL
    } shape_e;

    typedef struct packed {
        shape_e shape;
        logic   use_par;
        logic   dir_we;
        dir_e   dir_nxt;
        logic   pout_en;
    } ctrl_t;

    function automatic logic style_par_in(input io_style_e s);
        return (s == IO_PISO) || (s == IO_PIPO);
    endfunction

    function automatic logic style_par_out(input io_style_e s);
        return (s == IO_SIPO) || (s == IO_PIPO);
    endfunction

endpackage

// File: rtl/shreg_univ_decode.sv
module shreg_univ_decode
    import shreg_univ_pkg::*;
(
    input  io_style_e style,
    input  op_e       opc,
    output ctrl_t     ctrl
);
    logic par_src;

    always_comb begin
        par_src      = style_par_in(style);
        ctrl.use_par = par_src;
        ctrl.pout_en = style_par_out(style);
        ctrl.dir_we  = 1'b0;
        ctrl.dir_nxt = DIR_RIGHT;
        ctrl.shape   = SH_KEEP;
        unique case (opc)
            OP_HOLD: ctrl.shape = SH_KEEP;
            OP_LOAD: begin
                if (par_src) begin
                    ctrl.shape = SH_PASS;
                end else begin
                    ctrl.shape   = SH_RIGHT;
                    ctrl.dir_we  = 1'b1;
                    ctrl.dir_nxt = DIR_RIGHT;
                end
            end
            OP_LDSR: begin
                ctrl.shape   = SH_RIGHT;
                ctrl.dir_we  = 1'b1;
                ctrl.dir_nxt = DIR_RIGHT;
            end
            OP_LDSL: begin
                ctrl.shape   = SH_LEFT;
                ctrl.dir_we  = 1'b1;
                ctrl.dir_nxt = DIR_LEFT;
            end
            OP_ROTR: begin
                ctrl.shape   = SH_ROTR;
                ctrl.dir_we  = 1'b1;
                ctrl.dir_nxt = DIR_RIGHT;
            end
            OP_ROTL: begin
                ctrl.shape   = SH_ROTL;
                ctrl.dir_we  = 1'b1;
                ctrl.dir_nxt = DIR_LEFT;
            end
            OP_ASR: begin
                ctrl.shape   = SH_ASR;
                ctrl.dir_we  = 1'b1;
                ctrl.dir_nxt = DIR_RIGHT;
            end
            OP_ASL: begin
                ctrl.shape   = SH_ASL;
                ctrl.dir_we  = 1'b1;
                ctrl.dir_nxt = DIR_LEFT;
            end
        endcase
    end
endmodule

// File: rtl/shreg_univ_datapath.sv
module shreg_univ_datapath
    import shreg_univ_pkg::*;
#(
    parameter int W = 8
) (
    input  ctrl_t          ctrl,
    input  logic [W-1:0]   q,
    input  logic [W-1:0]   par_in,
    input  logic           ser_in,
    output logic [W-1:0]   d
);
    localparam int MSB = W - 1;

    generate
        if (W < 3) begin : g_width_bad
            $error("shreg_univ_datapath needs W of at least 3");
        end
    endgenerate

    logic [W-1:0] base;

    always_comb begin
        base = ctrl.use_par ? par_in : q;
        unique case (ctrl.shape)
            SH_KEEP:  d = q;
            SH_PASS:  d = base;
            SH_RIGHT: d = {ser_in, base[MSB:1]};
            SH_LEFT:  d = {base[MSB-1:0], ser_in};
            SH_ROTR:  d = {q[0], q[MSB:1]};
            SH_ROTL:  d = {q[MSB-1:0], q[MSB]};
            SH_ASR:   d = {q[MSB], q[MSB:1]};
            SH_ASL:   d = {q[MSB], q[MSB-2:0], 1'b0};
            default:  d = q;
        endcase
    end
endmodule

// File: rtl/shreg_univ_state.sv
module shreg_univ_state
    import shreg_univ_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output dir_e         dir
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            dir <= DIR_RIGHT;
        end else begin
            q <= d;
            if (ctrl.dir_we) begin
                dir <= ctrl.dir_nxt;
            end
        end
    end
endmodule

// File: rtl/shreg_univ_outsel.sv
module shreg_univ_outsel
    import shreg_univ_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         pout_en,
    input  logic [W-1:0] q,
    input  dir_e         dir,
    output logic [W-1:0] par_out,
    output logic         ser_out
);
    always_comb begin
        par_out = pout_en ? q : '0;
        ser_out = (dir == DIR_LEFT) ? q[W-1] : q[0];
    end
endmodule

// File: rtl/shreg_univ.sv
module shreg_univ
    import shreg_univ_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   io_mode,
    input  logic [2:0]   op,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] par_out,
    output logic         ser_out
);
    ctrl_t        ctrl;
    logic [W-1:0] d;
    logic [W-1:0] q;
    dir_e         dir;

    shreg_univ_decode u_dec (
        .style (io_style_e'(io_mode)),
        .opc   (op_e'(op)),
        .ctrl  (ctrl)
    );

    shreg_univ_datapath #(.W(W)) u_dp (
        .ctrl   (ctrl),
        .q      (q),
        .par_in (par_in),
        .ser_in (ser_in),
        .d      (d)
    );

    shreg_univ_state #(.W(W)) u_st (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .d    (d),
        .q    (q),
        .dir  (dir)
    );

    shreg_univ_outsel #(.W(W)) u_out (
        .pout_en (ctrl.pout_en),
        .q       (q),
        .dir     (dir),
        .par_out (par_out),
        .ser_out (ser_out)
    );
endmodule

// File: rtl/shreg_univ_chk.sv
module shreg_univ_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   io_mode,
    input logic [2:0]   op,
    input logic [W-1:0] par_in,
    input logic [W-1:0] par_out,
    input logic         ser_out,
    input logic [W-1:0] q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (q == '0 && par_out == '0 && ser_out == 1'b0));

    // R2
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b000) |=> (q == $past(q)));

    // R3
    par_load_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b001 && io_mode[1]) |=> (q == $past(par_in)));

    // R6
    rot_right_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b100) |=> (q == {$past(q[0]), $past(q[W-1:1])}));

    // R7
    asr_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b110) |=> (q[W-1] == $past(q[W-1]) && q[W-2:0] == $past(q[W-1:1])));

    // R8
    asl_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b111) |=> (q[0] == 1'b0 && q[W-1] == $past(q[W-1])));

    // R10
    pout_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (io_mode == 2'b01 || io_mode == 2'b10) |-> (par_out == '0));

    // R10
    pout_show_chk: assert property (@(posedge clk) disable iff (rst)
        (io_mode == 2'b00 || io_mode == 2'b11) |-> (par_out == q));
endmodule

bind shreg_univ shreg_univ_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .io_mode (io_mode),
    .op      (op),
    .par_in  (par_in),
    .par_out (par_out),
    .ser_out (ser_out),
    .q       (q)
);

// File: tb/sim_shreg_univ.sv
module sim_shreg_univ;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] io_mode = 2'b00;
    logic [2:0] op = 3'b000;
    logic [7:0] par_in = 8'h00;
    logic       ser_in = 1'b0;
    logic [7:0] par_out;
    logic       ser_out;

    int errors = 0;
    int checks = 0;
    logic [7:0] mq = 8'h00;
    logic       mdir = 1'b0;
    bit         done = 0;

    always #5 clk = ~clk;

    shreg_univ #(.W(8)) u0 (
        .clk(clk), .rst(rst), .io_mode(io_mode), .op(op),
        .par_in(par_in), .ser_in(ser_in), .par_out(par_out), .ser_out(ser_out)
    );

    function automatic string op_req(input logic [2:0] o);
        case (o)
            3'b000: return "R2";
            3'b001: return "R3";
            3'b010: return "R4";
            3'b011: return "R5";
            3'b100, 3'b101: return "R6";
            3'b110: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [7:0] mdl_q(input logic [7:0] q, input logic [1:0] io,
                                         input logic [2:0] o, input logic [7:0] p,
                                         input logic s);
        logic [7:0] src;
        src = io[1] ? p : q;
        case (o)
            3'b000: return q;
            3'b001: return io[1] ? p : {s, q[7:1]};
            3'b010: return {s, src[7:1]};
            3'b011: return {src[6:0], s};
            3'b100: return {q[0], q[7:1]};
            3'b101: return {q[6:0], q[7]};
            3'b110: return {q[7], q[7:1]};
            default: return {q[7], q[5:0], 1'b0};
        endcase
    endfunction

    function automatic logic mdl_dir(input logic dir, input logic [1:0] io, input logic [2:0] o);
        case (o)
            3'b000: return dir;
            3'b001: return io[1] ? dir : 1'b0;
            3'b011, 3'b101, 3'b111: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic compare(input string req);
        logic [7:0] ep;
        logic       es;
        ep = (io_mode == 2'b00 || io_mode == 2'b11) ? mq : 8'h00;
        es = mdir ? mq[7] : mq[0];
        checks++;
        if (par_out !== ep) begin
            errors++;
            $display("FAIL %s/R10 par_out mode=%b op=%b actual=%h expected=%h",
                     req, io_mode, op, par_out, ep);
        end
        checks++;
        if (ser_out !== es) begin
            errors++;
            $display("FAIL %s/R9 ser_out mode=%b op=%b actual=%b expected=%b",
                     req, io_mode, op, ser_out, es);
        end
    endtask

    task automatic step(input logic [1:0] io, input logic [2:0] o,
                        input logic [7:0] p, input logic s);
        io_mode = io;
        op      = o;
        par_in  = p;
        ser_in  = s;
        @(posedge clk);
        mq   = mdl_q(mq, io, o, p, s);
        mdir = mdl_dir(mdir, io, o);
        #1;
        compare(op_req(o));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        mq   = 8'h00;
        mdir = 1'b0;
        #1;
        io_mode = 2'b11;
        op      = 3'b000;
        #1;
        compare("R1");
        rst = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        do_reset();

        // Directed sweep over every style and operation, read back in PIPO hold.
        for (int m = 0; m < 4; m++) begin
            for (int o = 0; o < 8; o++) begin
                step(2'b11, 3'b001, 8'hA6, 1'b0);
                step(m[1:0], o[2:0], 8'h3C, 1'b1);
                step(2'b11, 3'b000, 8'hFF, 1'b0);
            end
        end

        // R7 / R8 corner: negative value under repeated arithmetic shifts.
        step(2'b11, 3'b001, 8'h81, 1'b0);
        repeat (3) step(2'b11, 3'b110, 8'h00, 1'b1);
        step(2'b11, 3'b001, 8'hC1, 1'b1);
        repeat (3) step(2'b11, 3'b111, 8'h00, 1'b1);

        // R9 corner: direction kept across hold and parallel load.
        step(2'b10, 3'b011, 8'h80, 1'b1);
        step(2'b10, 3'b000, 8'h00, 1'b0);
        step(2'b10, 3'b001, 8'h01, 1'b0);
        step(2'b01, 3'b001, 8'h00, 1'b1);

        // Constrained random mix.
        for (int i = 0; i < 2000; i++) begin
            step(2'($urandom), 3'($urandom), 8'($urandom), 1'($urandom));
        end

        // R1 mid-run reset.
        step(2'b11, 3'b001, 8'h5A, 1'b1);
        step(2'b11, 3'b101, 8'h00, 1'b0);
        do_reset();

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule